// File: doc/BRIEF.md
# Compact-Encoding Immediate Add and Load Unit

This unit carries out the immediate-form arithmetic of a 16-bit compressed instruction set. For each operation it receives a small opcode selector, an 8-bit immediate field, the low 32 bits of the source register, the stack pointer and the instruction's base PC, and a flag for 64-bit mode. It returns the value to write back, together with a code that names the destination register. Every variant forms its operands in its own way. The immediate is extended by zero or by sign, it may be scaled by a left shift, and it is paired with rx, sp, the word-aligned PC or zero. The two operands then go through one shared 32-bit adder.

Input and output are both valid/ready streams. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. The result sits in one register stage and appears on the cycle after acceptance. While `out_valid` is high and `out_ready` is low, the output holds steady and no new input is accepted. An accepted opcode that the unit does not recognise is consumed and produces no output.

Top module: `imm_alu_top`

## Requirements
- R1: Opcode 0 (load) writes the 8-bit immediate, zero-extended, to destination code 0 (rx).
- R2: Opcode 1 sign-extends bits [3:0] of the immediate, adds the result to rx and writes the sum to destination code 1 (ry).
- R3: Opcode 2 sign-extends the whole 8-bit immediate, adds it to rx and writes the sum to destination code 0 (rx).
- R4: Opcode 3 takes the immediate shifted left by 3, sign-extends it, adds it to sp and writes the sum to destination code 2 (sp).
- R5: Opcode 4 adds the immediate shifted left by 2 and zero-extended to the base PC with its two low bits cleared, and writes the sum to destination code 0 (rx).
- R6: Opcode 5 adds the immediate shifted left by 2 and zero-extended to sp, and writes the sum to destination code 0 (rx).
- R7: Every sum is taken modulo 2^32. A carry out of bit 31 is dropped and raises no indication.
- R8: When `mode64` is 1, bits [63:32] of the result copy bit 31 of the 32-bit sum. When `mode64` is 0, bits [63:32] are zero.
- R9: An accepted operation gives `out_valid` high on the next cycle. While `out_ready` is low, `out_data` and `out_dest` hold steady and `in_ready` is low.
- R10: An accepted opcode of 6 or 7 is consumed and produces no output: `out_valid` is low on the next cycle.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Unit can accept an operation |
| in_op | input | 3 | Operation selector (0..5 defined) |
| in_imm | input | 8 | Immediate field |
| in_rx | input | 32 | Source register value, low 32 bits |
| in_sp | input | 32 | Stack pointer, low 32 bits |
| in_pc | input | 32 | Base PC of the instruction |
| mode64 | input | 1 | 1 selects 64-bit result extension |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_dest | output | 2 | Destination: 0 rx, 1 ry, 2 sp |
| out_data | output | 64 | Value to write back |

## Verification
Each result is due exactly one clock edge after the edge that accepts its operation. The bench drives inputs on the falling edge, lets one rising edge capture them, and samples `out_valid`, `out_dest` and `out_data` on the following falling edge. In the back-pressure scenario the bench holds `out_ready` low for several cycles and checks at each falling edge that the held result and `in_ready` are unchanged. It then releases `out_ready` and expects the waiting operation's result one edge after release. For an illegal opcode the bench checks, at the same one-edge distance, that `out_valid` stays low.

// File: rtl/imm_alu_pkg.sv
package imm_alu_pkg;
  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_ADD_S4 = 3'd1,
    OP_ADD_S8 = 3'd2,
    OP_SP_ADJ = 3'd3,
    OP_PC_REL = 3'd4,
    OP_SP_REL = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    DST_RX = 2'd0,
    DST_RY = 2'd1,
    DST_SP = 2'd2
  } dest_e;
endpackage

// File: rtl/imm_operand_gen.sv
module imm_operand_gen
  import imm_alu_pkg::*;
#(
  parameter int ADD_W      = 32,
  parameter int IMM_W      = 8,
  parameter int SIMM_W     = 4,
  parameter int SP_SHIFT   = 3,
  parameter int WORD_SHIFT = 2
) (
  input  logic [2:0]       op,
  input  logic [IMM_W-1:0] imm,
  input  logic [ADD_W-1:0] rx,
  input  logic [ADD_W-1:0] sp,
  input  logic [ADD_W-1:0] pc,
  output logic [ADD_W-1:0] base,
  output logic [ADD_W-1:0] addend,
  output dest_e            dest,
  output logic             legal
);
  localparam int SPAD = ADD_W - IMM_W - SP_SHIFT;
  localparam int WPAD = ADD_W - IMM_W - WORD_SHIFT;
  localparam logic [ADD_W-1:0] PC_LOW_MASK = ADD_W'((1 << WORD_SHIFT) - 1);

  logic [ADD_W-1:0] imm_zext, imm_s4, imm_s8, imm_sp, imm_word;

  always_comb begin
    imm_zext = {{(ADD_W-IMM_W){1'b0}}, imm};
    imm_s4   = {{(ADD_W-SIMM_W){imm[SIMM_W-1]}}, imm[SIMM_W-1:0]};
    imm_s8   = {{(ADD_W-IMM_W){imm[IMM_W-1]}}, imm};
    imm_sp   = {{SPAD{imm[IMM_W-1]}}, imm, {SP_SHIFT{1'b0}}};
    imm_word = {{WPAD{1'b0}}, imm, {WORD_SHIFT{1'b0}}};
  end

  always_comb begin
    base   = '0;
    addend = '0;
    dest   = DST_RX;
    legal  = 1'b1;
    case (op)
      OP_LOAD:   begin base = '0;                 addend = imm_zext; dest = DST_RX; end
      OP_ADD_S4: begin base = rx;                 addend = imm_s4;   dest = DST_RY; end
      OP_ADD_S8: begin base = rx;                 addend = imm_s8;   dest = DST_RX; end
      OP_SP_ADJ: begin base = sp;                 addend = imm_sp;   dest = DST_SP; end
      OP_PC_REL: begin base = pc & ~PC_LOW_MASK;  addend = imm_word; dest = DST_RX; end
      OP_SP_REL: begin base = sp;                 addend = imm_word; dest = DST_RX; end
      default:   legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/imm_adder.sv
module imm_adder #(
  parameter int ADD_W = 32,
  parameter int XLEN  = 64
) (
  input  logic [ADD_W-1:0] a,
  input  logic [ADD_W-1:0] b,
  input  logic             mode64,
  output logic [XLEN-1:0]  result
);
  logic [ADD_W-1:0] sum;
  assign sum = a + b;

  generate
    if (XLEN > ADD_W) begin : g_wide
      localparam int EXT = XLEN - ADD_W;
      always_comb
        result = mode64 ? {{EXT{sum[ADD_W-1]}}, sum} : {{EXT{1'b0}}, sum};
    end else begin : g_narrow
      logic unused_mode;
      assign unused_mode = mode64;
      assign result = sum;
    end
  endgenerate
endmodule

// File: rtl/imm_alu_top.sv
module imm_alu_top
  import imm_alu_pkg::*;
#(
  parameter int ADD_W      = 32,
  parameter int XLEN       = 64,
  parameter int IMM_W      = 8,
  parameter int SIMM_W     = 4,
  parameter int SP_SHIFT   = 3,
  parameter int WORD_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic [IMM_W-1:0] in_imm,
  input  logic [ADD_W-1:0] in_rx,
  input  logic [ADD_W-1:0] in_sp,
  input  logic [ADD_W-1:0] in_pc,
  input  logic             mode64,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_dest,
  output logic [XLEN-1:0]  out_data
);
  logic [ADD_W-1:0] base, addend;
  dest_e            dest;
  logic             legal;
  logic [XLEN-1:0]  result;
  logic             fire;

  imm_operand_gen #(
    .ADD_W(ADD_W), .IMM_W(IMM_W), .SIMM_W(SIMM_W),
    .SP_SHIFT(SP_SHIFT), .WORD_SHIFT(WORD_SHIFT)
  ) u_opgen (
    .op(in_op), .imm(in_imm), .rx(in_rx), .sp(in_sp), .pc(in_pc),
    .base(base), .addend(addend), .dest(dest), .legal(legal)
  );

  imm_adder #(.ADD_W(ADD_W), .XLEN(XLEN)) u_add (
    .a(base), .b(addend), .mode64(mode64), .result(result)
  );

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_dest  <= DST_RX;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= fire && legal;
      if (fire && legal) begin
        out_dest <= dest;
        out_data <= result;
      end
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_dest));
  p_stall_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_op < 3'd6) |=> out_valid);
  p_illegal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_op >= 3'd6) |=> !out_valid);
  p_dest_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_dest != 2'd3);
  p_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[XLEN-1:ADD_W] == '0) ||
                  (out_data[XLEN-1:ADD_W] == '1 && out_data[ADD_W-1]));
endmodule

// File: tb/imm_alu_top_tb.sv
module imm_alu_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [7:0]  in_imm = '0;
  logic [31:0] in_rx = '0, in_sp = '0, in_pc = '0;
  logic        mode64 = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_dest;
  logic [63:0] out_data;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  imm_alu_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_imm(in_imm), .in_rx(in_rx), .in_sp(in_sp), .in_pc(in_pc),
    .mode64(mode64), .out_valid(out_valid), .out_ready(out_ready),
    .out_dest(out_dest), .out_data(out_data)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ext(input logic [31:0] s, input logic m);
    return m ? {{32{s[31]}}, s} : {32'h0, s};
  endfunction

  // drive one operation on a falling edge, let one rising edge take it
  task automatic issue(input logic [2:0] op, input logic [7:0] imm,
                       input logic [31:0] rx, input logic [31:0] sp,
                       input logic [31:0] pc, input logic m);
    @(negedge clk);
    in_op = op; in_imm = imm; in_rx = rx; in_sp = sp; in_pc = pc; mode64 = m;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic [1:0] d, input logic [63:0] v);
    chk(req, {63'h0, out_valid}, 64'd1);
    chk(req, {62'h0, out_dest}, {62'h0, d});
    chk(req, out_data, v);
  endtask

  task automatic t_reset_r11();
    chk("R11", {63'h0, out_valid}, 64'd0);
    chk("R11", {63'h0, in_ready}, 64'd1);
  endtask

  task automatic t_load_r1();
    issue(3'd0, 8'hA5, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b1);
    expect_out("R1", 2'd0, 64'h0000_0000_0000_00A5);
  endtask

  task automatic t_add4_r2();
    issue(3'd1, 8'hFF, 32'h0000_0010, 32'h0, 32'h0, 1'b0); // only low nibble F = -1
    expect_out("R2", 2'd1, 64'h0000_0000_0000_000F);
    issue(3'd1, 8'h07, 32'h0000_0010, 32'h0, 32'h0, 1'b0);
    expect_out("R2", 2'd1, 64'h0000_0000_0000_0017);
  endtask

  task automatic t_add8_r3();
    issue(3'd2, 8'h80, 32'h0000_0100, 32'h0, 32'h0, 1'b0);
    expect_out("R3", 2'd0, 64'h0000_0000_0000_0080);
  endtask

  task automatic t_spadj_r4();
    issue(3'd3, 8'h80, 32'h0, 32'h0000_1000, 32'h0, 1'b0);
    expect_out("R4", 2'd2, 64'h0000_0000_0000_0C00);
    issue(3'd3, 8'h01, 32'h0, 32'h0000_1000, 32'h0, 1'b0);
    expect_out("R4", 2'd2, 64'h0000_0000_0000_1008);
  endtask

  task automatic t_pcrel_r5();
    issue(3'd4, 8'hFF, 32'h0, 32'h0, 32'h0000_1003, 1'b0);
    expect_out("R5", 2'd0, 64'h0000_0000_0000_13FC);
  endtask

  task automatic t_sprel_r6();
    issue(3'd5, 8'hFF, 32'h0, 32'h0000_0100, 32'h0, 1'b0);
    expect_out("R6", 2'd0, 64'h0000_0000_0000_04FC);
  endtask

  task automatic t_wrap_r7();
    issue(3'd2, 8'h01, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b0);
    expect_out("R7", 2'd0, 64'h0);
    issue(3'd2, 8'h01, 32'h7FFF_FFFF, 32'h0, 32'h0, 1'b0);
    expect_out("R7", 2'd0, 64'h0000_0000_8000_0000);
  endtask

  task automatic t_mode_r8();
    issue(3'd2, 8'h01, 32'h7FFF_FFFF, 32'h0, 32'h0, 1'b1);
    expect_out("R8", 2'd0, ext(32'h8000_0000, 1'b1));
    issue(3'd3, 8'hFF, 32'h0, 32'h0000_0000, 32'h0, 1'b1);
    expect_out("R8", 2'd2, 64'hFFFF_FFFF_FFFF_FFF8);
    issue(3'd3, 8'hFF, 32'h0, 32'h0000_0000, 32'h0, 1'b0);
    expect_out("R8", 2'd2, 64'h0000_0000_FFFF_FFF8);
  endtask

  task automatic t_backpressure_r9();
    @(negedge clk);
    out_ready = 1'b0;
    issue(3'd0, 8'h11, 32'h0, 32'h0, 32'h0, 1'b0);
    expect_out("R9", 2'd0, 64'h11);
    in_op = 3'd0; in_imm = 8'h22; in_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      chk("R9", {63'h0, in_ready}, 64'd0);
      @(negedge clk);
      expect_out("R9", 2'd0, 64'h11);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    expect_out("R9", 2'd0, 64'h22);
    @(negedge clk);
    chk("R9", {63'h0, out_valid}, 64'd0);
  endtask

  task automatic t_illegal_r10();
    issue(3'd6, 8'h33, 32'h5, 32'h5, 32'h5, 1'b0);
    chk("R10", {63'h0, out_valid}, 64'd0);
    issue(3'd7, 8'h33, 32'h5, 32'h5, 32'h5, 1'b1);
    chk("R10", {63'h0, out_valid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r11();
    rst_n = 1'b1;
    t_load_r1();
    t_add4_r2();
    t_add8_r3();
    t_spadj_r4();
    t_pcrel_r5();
    t_sprel_r6();
    t_wrap_r7();
    t_mode_r8();
    t_backpressure_r9();
    t_illegal_r10();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule